// File: doc/BRIEF.md
# Codec Channel Standby Supervisor

This block decides, for a PCM voice codec, whether the transmit and receive channels are running, idle or powered down, and whether the transmit data and slot-strobe pins may be driven. Each channel watches its own frame-sync input: a sync held low long enough puts that channel into standby, and the next rising edge of that sync brings it back. The two channels are timed separately, so either can idle alone.

An asynchronous active-low power-down input overrides both channels. The transmit pins are blanked for a startup period after reset and again after every power-down release. They are also released to high impedance when the transmit master clock stops. Loss of that clock is detected by a counter on a free-running reference clock, and synchronized edges of the master clock restart it. All windows are parameters counted in reference-clock cycles, so the block runs at full scale in silicon and with short windows in simulation.

Top module: `codec_standby_sup`

## Requirements
- R1: When `fs_tx` stays low, `tx_standby` rises between STBY_CYC+1 and STBY_CYC+5 reference cycles after the drop.
- R2: Transmit and receive standby are timed independently: a low `fs_rx` sets only `rx_standby` and leaves `tx_standby` unchanged.
- R3: A rising edge on a channel's frame sync clears that channel's standby within 4 cycles and restarts its full absence window.
- R4: A low `pdn_n` sets `pwr_down` by the third reference edge. A high `pdn_n` keeps the block active.
- R5: `tx_oe` is 0 while `pwr_down` or `tx_standby` is 1.
- R6: `tx_oe` stays 0 for BLANK_CYC cycles after reset release and again after every fall of `pwr_down`.
- R7: If `mclk_tx` shows no edge for CLK_LOSS_CYC reference cycles, `mclk_lost` goes to 1 and `tx_oe` to 0. The next edge clears `mclk_lost` within a few cycles.
- R8: `sig_force_low` is 1 when `pwr_down` is 1, or when both channels are in standby.
- R9: `sig_oe` is 0 only when the transmit channel is in standby, the receive channel is active and the block is not powered down. Otherwise it is 1.
- R10: `chan_mode` encodes the channel state: 0 means both active, 1 means receive in standby only, 2 means transmit in standby only, 3 means both in standby (bit 1 = transmit standby, bit 0 = receive standby).
- R11: Right after reset, both standby flags, `pwr_down` and `mclk_lost` are 0, and `tx_oe` is 0 because of startup blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Asynchronous power-down request, low = power down |
| fs_tx | input | 1 | Transmit frame sync, asynchronous |
| fs_rx | input | 1 | Receive frame sync, asynchronous |
| mclk_tx | input | 1 | Transmit master clock, observed as data |
| tx_standby | output | 1 | Transmit channel in standby |
| rx_standby | output | 1 | Receive channel in standby |
| chan_mode | output | 2 | Combined channel state code |
| pwr_down | output | 1 | Block is powered down |
| mclk_lost | output | 1 | Master clock has stopped |
| tx_oe | output | 1 | Output enable for transmit data and slot strobe |
| sig_oe | output | 1 | Output enable for the receive signaling pin |
| sig_force_low | output | 1 | Signaling pin is driven low |

## Verification
The main channel-state function is driven through a series of sync-level pairs: both high, transmit low alone, receive low alone, both low, and a return to both high. These separate the four `chan_mode` codes and the three signaling behaviours (normal, high impedance, forced low). Visiting transmit-only and receive-only in turn shows that the channels do not share a timer. The absence window is probed a few cycles before and after its limit. A short sync pulse inside standby shows that the window restarts rather than carrying on from where it was. Power-down release and clock stop-and-restart are checked separately, because only these two reveal the blanking path and the clock-loss path.

// File: rtl/csup_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the codec standby supervisor.
// Assumes channel index 0 is transmit and index 1 is receive.
package csup_pkg;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;
    localparam int CH_NUM = 2;

    // Bit 1 = transmit standby, bit 0 = receive standby.
    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_TX_ONLY = 2'd1,
        MODE_RX_ONLY = 2'd2,
        MODE_IDLE    = 2'd3
    } csup_mode_e;
endpackage

// File: rtl/csup_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is a level that is stable for at least two reference cycles.
module csup_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Move the inputs into the reference domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/csup_timer.sv
`timescale 1ns/1ps
// Saturating elapsed-cycle timer: counts reference cycles since the last restart.
// done is 1 once LIMIT cycles have passed without a restart.
// Assumes LIMIT >= 1.
module csup_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count up to LIMIT and hold, back to zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/csup_chan.sv
`timescale 1ns/1ps
// Per-channel standby tracker: the channel idles after its synchronized
// frame sync has been low for STBY_CYC cycles, and wakes on the next rising edge.
// Assumes fs_s is already synchronized to clk.
module csup_chan #(
    parameter int STBY_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_s,
    output logic standby
);
    logic fs_d;
    logic fs_rise;
    logic expired;

    // Remember the previous sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_d <= 1'b0;
        else        fs_d <= fs_s;
    end

    assign fs_rise = fs_s & ~fs_d;

    csup_timer #(.LIMIT(STBY_CYC)) u_absence (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fs_s),
        .done    (expired)
    );

    // A sync edge wakes the channel; a full absence window sends it to standby.
    always_ff @(posedge clk) begin
        if (!rst_n)       standby <= 1'b0;
        else if (fs_rise) standby <= 1'b0;
        else if (expired) standby <= 1'b1;
    end
endmodule

// File: rtl/codec_standby_sup.sv
`timescale 1ns/1ps
// Codec standby supervisor: sets per-channel standby from frame-sync absence,
// handles asynchronous power-down, blanks the transmit pins after power-up
// and releases them when the transmit master clock stops.
// Assumes clk_ref runs freely and several times faster than mclk_tx.
module codec_standby_sup
    import csup_pkg::*;
#(
    parameter int STBY_CYC     = 15_000_000,
    parameter int BLANK_CYC    = 25_000,
    parameter int CLK_LOSS_CYC = 1_000
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       fs_tx,
    input  logic       fs_rx,
    input  logic       mclk_tx,
    output logic       tx_standby,
    output logic       rx_standby,
    output logic [1:0] chan_mode,
    output logic       pwr_down,
    output logic       mclk_lost,
    output logic       tx_oe,
    output logic       sig_oe,
    output logic       sig_force_low
);
    localparam int SYNC_W = CH_NUM + 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_in;
    logic [CH_NUM-1:0] fs_s;
    logic [CH_NUM-1:0] stby;
    logic              pdn_s;
    logic              mclk_s;
    logic              mclk_d;
    logic              pwr_down_q;
    logic              blank_done;
    csup_mode_e        mode;

    assign raw_in = {pdn_n, mclk_tx, fs_rx, fs_tx};

    csup_sync #(.W(SYNC_W), .RST_VAL({1'b1, {(SYNC_W-1){1'b0}}})) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign fs_s   = sync_in[CH_NUM-1:0];
    assign mclk_s = sync_in[CH_NUM];
    assign pdn_s  = sync_in[CH_NUM+1];

    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
        csup_chan #(.STBY_CYC(STBY_CYC)) u_chan (
            .clk     (clk_ref),
            .rst_n   (rst_n),
            .fs_s    (fs_s[ch]),
            .standby (stby[ch])
        );
    end

    // Register the power-down request once it has crossed into this domain.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) pwr_down_q <= 1'b0;
        else        pwr_down_q <= ~pdn_s;
    end

    // Keep the previous master-clock sample for edge detection.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) mclk_d <= 1'b0;
        else        mclk_d <= mclk_s;
    end

    csup_timer #(.LIMIT(CLK_LOSS_CYC)) u_clk_watch (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (mclk_s ^ mclk_d),
        .done    (mclk_lost)
    );

    csup_timer #(.LIMIT(BLANK_CYC)) u_blank (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (pwr_down_q),
        .done    (blank_done)
    );

    // Combine the channel flags into the state code.
    always_comb begin
        mode = csup_mode_e'({stby[CH_TX], stby[CH_RX]});
    end

    assign tx_standby    = stby[CH_TX];
    assign rx_standby    = stby[CH_RX];
    assign chan_mode     = mode;
    assign pwr_down      = pwr_down_q;
    assign tx_oe         = ~pwr_down_q & ~stby[CH_TX] & blank_done & ~mclk_lost;
    assign sig_force_low = pwr_down_q | (mode == MODE_IDLE);
    assign sig_oe        = pwr_down_q | (mode != MODE_RX_ONLY);
endmodule

// File: rtl/csup_checker.sv
`timescale 1ns/1ps
// Timing properties of the standby supervisor, attached to it by bind.
// Assumes frame-sync pulses last at least three reference cycles.
module csup_checker (
    input logic       clk_ref,
    input logic       rst_n,
    input logic       pdn_n,
    input logic       fs_tx,
    input logic       fs_rx,
    input logic       mclk_tx,
    input logic       tx_standby,
    input logic       rx_standby,
    input logic       pwr_down,
    input logic       mclk_lost,
    input logic       tx_oe,
    input logic       sig_oe,
    input logic       sig_force_low
);
    logic [2:0] age;

    // Count cycles since reset so that $past never reaches before it.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)        age <= '0;
        else if (age != 7) age <= age + 1'b1;
    end

    p_pdn_latency_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 4 && !pdn_n && !$past(pdn_n) && !$past(pdn_n, 2) && !$past(pdn_n, 3)) |-> pwr_down);

    p_tx_entry_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 3 && $rose(tx_standby)) |-> !$past(fs_tx, 2));

    p_rx_entry_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 3 && $rose(rx_standby)) |-> !$past(fs_rx, 2));

    p_rx_wake_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 3 && $fell(rx_standby)) |-> $past(fs_rx, 2));

    p_tx_wake_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 3 && $fell(tx_standby)) |-> $past(fs_tx, 2));

    p_blank_after_pdn_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 2 && $fell(pwr_down)) |-> !tx_oe);

    p_clk_stopped_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 2 && $rose(mclk_lost)) |-> $stable(mclk_tx));

    p_low_is_driven_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        sig_force_low |-> sig_oe);

    p_tx_quiet_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (age >= 2 && $rose(tx_oe)) |-> (!tx_standby && !pwr_down && !mclk_lost));
endmodule

bind codec_standby_sup csup_checker u_chk (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .pdn_n         (pdn_n),
    .fs_tx         (fs_tx),
    .fs_rx         (fs_rx),
    .mclk_tx       (mclk_tx),
    .tx_standby    (tx_standby),
    .rx_standby    (rx_standby),
    .pwr_down      (pwr_down),
    .mclk_lost     (mclk_lost),
    .tx_oe         (tx_oe),
    .sig_oe        (sig_oe),
    .sig_force_low (sig_force_low)
);

// File: tb/sim_codec_standby_sup.sv
`timescale 1ns/1ps
module sim_codec_standby_sup;
    localparam int STBY  = 40;
    localparam int BLANK = 30;
    localparam int LOSS  = 16;

    // Fields: [6] fs_tx, [5] fs_rx, [4:3] mode, [2] sig_oe, [1] sig_force_low, [0] tx_oe
    localparam int NVEC = 6;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1100101,
        7'b0110000,
        7'b1100101,
        7'b1001101,
        7'b0011110,
        7'b1100101
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn_n = 1'b1;
    logic       fs_tx = 1'b1;
    logic       fs_rx = 1'b1;
    logic       mclk_tx = 1'b0;
    logic       mclk_run = 1'b1;
    logic       tx_standby, rx_standby, pwr_down, mclk_lost, tx_oe, sig_oe, sig_force_low;
    logic [1:0] chan_mode;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;
    always #40 if (mclk_run) mclk_tx = ~mclk_tx;

    codec_standby_sup #(.STBY_CYC(STBY), .BLANK_CYC(BLANK), .CLK_LOSS_CYC(LOSS)) u0 (
        .clk_ref(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .mclk_tx(mclk_tx), .tx_standby(tx_standby), .rx_standby(rx_standby),
        .chan_mode(chan_mode), .pwr_down(pwr_down), .mclk_lost(mclk_lost),
        .tx_oe(tx_oe), .sig_oe(sig_oe), .sig_force_low(sig_force_low)
    );

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        // R11: state just after reset
        chk("R11", "tx_standby", tx_standby, 0);
        chk("R11", "rx_standby", rx_standby, 0);
        chk("R11", "pwr_down", pwr_down, 0);
        chk("R11", "mclk_lost", mclk_lost, 0);
        chk("R11", "tx_oe blanked", tx_oe, 0);
        cycles(BLANK + 5);
        chk("R6", "tx_oe after startup blanking", tx_oe, 1);

        // Table of sync levels and expected channel state
        for (int i = 0; i < NVEC; i++) begin
            fs_tx = VEC[i][6];
            fs_rx = VEC[i][5];
            cycles(STBY + 10);
            chk("R10", "chan_mode", chan_mode, VEC[i][4:3]);
            chk("R9", "sig_oe", sig_oe, VEC[i][2]);
            chk("R8", "sig_force_low", sig_force_low, VEC[i][1]);
            chk("R5", "tx_oe", tx_oe, VEC[i][0]);
        end

        // R1 / R2: absence window edges, receive unaffected
        fs_tx = 1'b0;
        cycles(STBY);
        chk("R1", "tx_standby before limit", tx_standby, 0);
        cycles(6);
        chk("R1", "tx_standby after limit", tx_standby, 1);
        chk("R2", "rx_standby untouched", rx_standby, 0);

        // R3: short sync pulse wakes the channel and restarts the window
        fs_tx = 1'b1;
        cycles(3);
        fs_tx = 1'b0;
        cycles(2);
        chk("R3", "tx_standby cleared by pulse", tx_standby, 0);
        cycles(STBY - 5);
        chk("R3", "window restarted", tx_standby, 0);
        cycles(15);
        chk("R3", "standby again after new window", tx_standby, 1);
        fs_tx = 1'b1;
        cycles(5);
        chk("R3", "tx wake", tx_standby, 0);

        // R4 / R5 / R8 / R9: power-down
        pdn_n = 1'b0;
        cycles(3);
        chk("R4", "pwr_down", pwr_down, 1);
        chk("R5", "tx_oe in power-down", tx_oe, 0);
        chk("R8", "sig_force_low in power-down", sig_force_low, 1);
        chk("R9", "sig_oe in power-down", sig_oe, 1);
        pdn_n = 1'b1;
        cycles(4);
        chk("R4", "pwr_down released", pwr_down, 0);
        chk("R6", "tx_oe blanked after release", tx_oe, 0);
        cycles(BLANK - 6);
        chk("R6", "tx_oe still blanked", tx_oe, 0);
        cycles(12);
        chk("R6", "tx_oe after blanking", tx_oe, 1);

        // R7: master clock stops and restarts
        mclk_run = 1'b0;
        cycles(LOSS + 8);
        chk("R7", "mclk_lost", mclk_lost, 1);
        chk("R7", "tx_oe with clock lost", tx_oe, 0);
        mclk_run = 1'b1;
        cycles(10);
        chk("R7", "mclk_lost cleared", mclk_lost, 0);
        chk("R7", "tx_oe restored", tx_oe, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule